// File: doc/BRIEF.md
# Load/Store Ordering Queues with Address Disambiguation

This block sits between the issue stage of a dynamically scheduled core and data memory. Memory instructions are allocated into it in program order, one per cycle, into either an eight-entry load queue or an eight-entry store queue. Their addresses, and for stores the write data, arrive later on write-back ports tagged with the entry index that allocation handed out. The block alone decides when each load may read memory and when each store may write it. The aim is that every value a load returns is the one the program order implies.

Three memory hazards are resolved by comparing addresses between the two queues. A read-after-write hazard is resolved by forwarding: a load whose address equals that of an older store still waiting in the store queue takes the data of the youngest such store, and memory is not read. A write-after-read hazard is resolved by holding a store while any older load still in the load queue has the same address or an address not yet known. Write-after-write order comes from stores leaving the store queue strictly in program order, so the younger of two stores to one word reaches memory last. A load whose older stores still have unknown addresses waits until those addresses arrive. Loads complete in program order, and so do stores.

Each completed load or store is reported on a completion output. Stores are reported together with their memory write and loads when their data is known. Addresses are compared as whole words.

Top module: `mem_order_lsq`

## Requirements
- R1: Each queue holds 8 entries. `alloc_ready` is low while the queue selected by `alloc_store` is full, and high while that queue has room, whatever the state of the other queue. `alloc_idx` names the entry taken. Indices count up from 0 in each queue and wrap from 7 to 0.
- R2: Loads complete (`done_valid`=1, `done_store`=0) in allocation order, whatever order their addresses arrive in.
- R3: Stores write memory and complete in allocation order, whatever order their addresses arrive in. Of two stores to one address, the younger one therefore writes last and its data stays in memory.
- R4: A load whose address equals that of an older store still in the store queue completes with that store's data, and no memory read is issued for it.
- R5: When several older stores in the queue match a load, the load receives the data of the youngest of them.
- R6: A load does not read memory or complete while any store allocated before it has no address yet.
- R7: A store does not write memory while any load allocated before it is still queued with an equal or unknown address. A store to a different address may write before an older load reads.
- R8: A load with no matching older store issues one read (`mem_req_write`=0) for its address and completes with `mem_rsp_data`. At most one read is outstanding at any time.
- R9: After reset no memory request and no completion is presented, `alloc_ready` is high and `alloc_idx` is 0.
- R10: A store allocated after a load never supplies data to that load, even with an equal address known earlier.
- R11: A store's completion appears in the same cycle as its write request and carries the written data and the store's queue index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocate one memory instruction this cycle |
| alloc_store | input | 1 | 1 selects the store queue, 0 the load queue |
| alloc_ready | output | 1 | Selected queue has a free entry |
| alloc_idx | output | IW | Entry index assigned in the selected queue |
| ld_wb_valid | input | 1 | Load address write-back |
| ld_wb_idx | input | IW | Load queue entry written back |
| ld_wb_addr | input | AW | Load word address |
| st_wb_valid | input | 1 | Store address and data write-back |
| st_wb_idx | input | IW | Store queue entry written back |
| st_wb_addr | input | AW | Store word address |
| st_wb_data | input | DW | Store data |
| mem_req_valid | output | 1 | Memory request this cycle |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | AW | Request word address |
| mem_req_wdata | output | DW | Write data |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | DW | Read data |
| done_valid | output | 1 | One instruction completed |
| done_store | output | 1 | Completed instruction is a store |
| done_idx | output | IW | Queue index of the completed instruction |
| done_data | output | DW | Load result or stored data |

## Verification
A lone load to an untouched word shows the plain read path against the forwarding path. A load placed between an older load and a store, all to one word, shows whether the store is held until the older load has read the old value, and whether the younger load takes the store's data without touching memory. Two stores and a load to one word tell the youngest-match choice apart from the oldest and fix the final memory value. Withheld store addresses and withheld load addresses show the two waiting rules and that unrelated stores may pass. Addresses written back in reverse order to full queues show that allocation stalls per queue and completion order ignores write-back order.

// File: rtl/lsq_pkg.sv
// Shared types for the load/store ordering queues.
// Assumes one memory action is chosen per cycle from the list below.
package lsq_pkg;
    typedef enum logic [2:0] {
        ACT_IDLE,     // nothing to do
        ACT_LD_RSP,   // head load takes returned read data
        ACT_LD_FWD,   // head load takes forwarded store data
        ACT_ST_WR,    // head store writes memory
        ACT_LD_RD     // head load issues a read
    } lsq_act_e;
endpackage

// File: rtl/lsq_ring.sv
// Head/tail/occupancy bookkeeping for one circular queue.
// Assumes push is only raised while not full and pop only while not empty.
module lsq_ring #(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic [IW-1:0]    head,
    output logic [IW-1:0]    tail,
    output logic             full,
    output logic             empty,
    output logic [DEPTH-1:0] occ
);
    logic [CW-1:0] count;

    function automatic logic [IW-1:0] step(input logic [IW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    // Advance pointers and entry count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) tail <= step(tail);
            if (pop)  head <= step(head);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assign full  = (int'(count) == DEPTH);
    assign empty = (count == '0);

    // Mark each slot that lies within head .. head+count-1.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            int rel;
            rel = (i >= int'(head)) ? i - int'(head) : i + DEPTH - int'(head);
            occ[i] = (rel < int'(count));
        end
    end
endmodule

// File: rtl/lsq_youngest.sv
// Picks the youngest flagged slot of a circular queue, scanning from the head.
// Assumes flagged slots are all occupied, so distance from base is age order.
module lsq_youngest #(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] hit,
    input  logic [IW-1:0]    base,
    output logic             found,
    output logic [IW-1:0]    sel
);
    // Last hit met while walking oldest to youngest wins.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            int p;
            p = int'(base) + k;
            if (p >= DEPTH) p = p - DEPTH;
            if (hit[p]) begin
                found = 1'b1;
                sel   = IW'(p);
            end
        end
    end
endmodule

// File: rtl/mem_order_lsq.sv
// Program-ordered load and store queues with cross address checks.
// Each entry records which entries of the other queue are older (age mask),
// captured at allocation and cleared as those entries leave.
// Assumes write-backs target allocated entries and memory accepts every
// request; a read is answered by mem_rsp_valid in a later cycle.
module mem_order_lsq import lsq_pkg::*; #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_valid,
    input  logic          alloc_store,
    output logic          alloc_ready,
    output logic [IW-1:0] alloc_idx,
    input  logic          ld_wb_valid,
    input  logic [IW-1:0] ld_wb_idx,
    input  logic [AW-1:0] ld_wb_addr,
    input  logic          st_wb_valid,
    input  logic [IW-1:0] st_wb_idx,
    input  logic [AW-1:0] st_wb_addr,
    input  logic [DW-1:0] st_wb_data,
    output logic          mem_req_valid,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data,
    output logic          done_valid,
    output logic          done_store,
    output logic [IW-1:0] done_idx,
    output logic [DW-1:0] done_data
);
    logic [IW-1:0]    lq_head, lq_tail, sq_head, sq_tail;
    logic             lq_full, lq_empty, sq_full, sq_empty;
    logic [DEPTH-1:0] lq_occ, sq_occ;
    logic             ld_push, st_push, ld_pop, st_pop;

    logic [DEPTH-1:0] lq_av, sq_av;
    logic [AW-1:0]    lq_addr  [DEPTH];
    logic [AW-1:0]    sq_addr  [DEPTH];
    logic [DW-1:0]    sq_data  [DEPTH];
    logic [DEPTH-1:0] lq_smask [DEPTH];
    logic [DEPTH-1:0] sq_lmask [DEPTH];

    logic [DEPTH-1:0] st_hit, ld_blk, sq_pop_vec, lq_pop_vec;
    logic             fwd_hit, st_unknown, ld_head_ok, st_ok, ld_busy;
    logic [IW-1:0]    fwd_idx;
    lsq_act_e         act;

    assign ld_push = alloc_valid && !alloc_store && !lq_full;
    assign st_push = alloc_valid &&  alloc_store && !sq_full;
    assign alloc_ready = alloc_store ? !sq_full : !lq_full;
    assign alloc_idx   = alloc_store ? sq_tail  : lq_tail;

    lsq_ring #(.DEPTH(DEPTH)) u_lq_ring (
        .clk(clk), .rst_n(rst_n), .push(ld_push), .pop(ld_pop),
        .head(lq_head), .tail(lq_tail), .full(lq_full), .empty(lq_empty), .occ(lq_occ)
    );

    lsq_ring #(.DEPTH(DEPTH)) u_sq_ring (
        .clk(clk), .rst_n(rst_n), .push(st_push), .pop(st_pop),
        .head(sq_head), .tail(sq_tail), .full(sq_full), .empty(sq_empty), .occ(sq_occ)
    );

    // Per-slot compares: older stores matching the head load, older loads blocking the head store.
    for (genvar j = 0; j < DEPTH; j++) begin : g_cmp
        assign st_hit[j] = lq_smask[lq_head][j] && sq_av[j] && (sq_addr[j] == lq_addr[lq_head]);
        assign ld_blk[j] = sq_lmask[sq_head][j] && (!lq_av[j] || (lq_addr[j] == sq_addr[sq_head]));
    end

    lsq_youngest #(.DEPTH(DEPTH)) u_pick (
        .hit(st_hit), .base(sq_head), .found(fwd_hit), .sel(fwd_idx)
    );

    assign st_unknown = |(lq_smask[lq_head] & ~sq_av);
    assign ld_head_ok = !lq_empty && lq_av[lq_head] && !ld_busy && !st_unknown;
    assign st_ok      = !sq_empty && sq_av[sq_head] && !(|ld_blk);

    // Choose the single memory action of this cycle.
    always_comb begin
        if (ld_busy && mem_rsp_valid)  act = ACT_LD_RSP;
        else if (ld_head_ok && fwd_hit) act = ACT_LD_FWD;
        else if (st_ok)                 act = ACT_ST_WR;
        else if (ld_head_ok)            act = ACT_LD_RD;
        else                            act = ACT_IDLE;
    end

    assign ld_pop     = (act == ACT_LD_RSP) || (act == ACT_LD_FWD);
    assign st_pop     = (act == ACT_ST_WR);
    assign sq_pop_vec = st_pop ? (DEPTH'(1) << sq_head) : '0;
    assign lq_pop_vec = ld_pop ? (DEPTH'(1) << lq_head) : '0;

    // Load entries: clear on allocation, fill on write-back, drop departed stores from age masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lq_av <= '0;
            for (int e = 0; e < DEPTH; e++) begin
                lq_addr[e]  <= '0;
                lq_smask[e] <= '0;
            end
        end else begin
            for (int e = 0; e < DEPTH; e++) begin
                if (ld_push && IW'(e) == lq_tail) begin
                    lq_av[e]    <= 1'b0;
                    lq_smask[e] <= sq_occ & ~sq_pop_vec;
                end else begin
                    if (ld_wb_valid && IW'(e) == ld_wb_idx) begin
                        lq_av[e]   <= 1'b1;
                        lq_addr[e] <= ld_wb_addr;
                    end
                    if (st_pop) lq_smask[e][sq_head] <= 1'b0;
                end
            end
        end
    end

    // Store entries: same scheme, with age masks over the load queue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_av <= '0;
            for (int e = 0; e < DEPTH; e++) begin
                sq_addr[e]  <= '0;
                sq_data[e]  <= '0;
                sq_lmask[e] <= '0;
            end
        end else begin
            for (int e = 0; e < DEPTH; e++) begin
                if (st_push && IW'(e) == sq_tail) begin
                    sq_av[e]    <= 1'b0;
                    sq_lmask[e] <= lq_occ & ~lq_pop_vec;
                end else begin
                    if (st_wb_valid && IW'(e) == st_wb_idx) begin
                        sq_av[e]   <= 1'b1;
                        sq_addr[e] <= st_wb_addr;
                        sq_data[e] <= st_wb_data;
                    end
                    if (ld_pop) sq_lmask[e][lq_head] <= 1'b0;
                end
            end
        end
    end

    // Track the one outstanding read.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ld_busy <= 1'b0;
        else if (act == ACT_LD_RD)   ld_busy <= 1'b1;
        else if (act == ACT_LD_RSP)  ld_busy <= 1'b0;
    end

    // Register the memory request and completion outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req_valid <= 1'b0;
            mem_req_write <= 1'b0;
            mem_req_addr  <= '0;
            mem_req_wdata <= '0;
            done_valid    <= 1'b0;
            done_store    <= 1'b0;
            done_idx      <= '0;
            done_data     <= '0;
        end else begin
            mem_req_valid <= (act == ACT_ST_WR) || (act == ACT_LD_RD);
            mem_req_write <= (act == ACT_ST_WR);
            mem_req_addr  <= (act == ACT_ST_WR) ? sq_addr[sq_head] : lq_addr[lq_head];
            mem_req_wdata <= sq_data[sq_head];
            done_valid    <= (act == ACT_ST_WR) || ld_pop;
            done_store    <= (act == ACT_ST_WR);
            done_idx      <= (act == ACT_ST_WR) ? sq_head : lq_head;
            case (act)
                ACT_LD_RSP: done_data <= mem_rsp_data;
                ACT_LD_FWD: done_data <= sq_data[fwd_idx];
                default:    done_data <= sq_data[sq_head];
            endcase
        end
    end
endmodule

// File: rtl/lsq_checker.sv
// Port-level properties of mem_order_lsq, bound to every instance.
// Keeps its own counts of allocations and completions seen at the ports.
module lsq_checker #(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          alloc_valid,
    input logic          alloc_store,
    input logic          alloc_ready,
    input logic          mem_req_valid,
    input logic          mem_req_write,
    input logic          mem_rsp_valid,
    input logic          done_valid,
    input logic          done_store,
    input logic [IW-1:0] done_idx
);
    logic [IW:0]   ld_cnt, st_cnt;
    logic [IW-1:0] exp_ld, exp_st;
    logic          rd_pend;
    logic          ld_done_now, st_done_now;

    assign ld_done_now = done_valid && !done_store;
    assign st_done_now = done_valid &&  done_store;

    function automatic logic [IW-1:0] step(input logic [IW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    // Occupancy as seen at the ports, expected next indices, read in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_cnt  <= '0;
            st_cnt  <= '0;
            exp_ld  <= '0;
            exp_st  <= '0;
            rd_pend <= 1'b0;
        end else begin
            ld_cnt <= ld_cnt + (alloc_valid && alloc_ready && !alloc_store) - ld_done_now;
            st_cnt <= st_cnt + (alloc_valid && alloc_ready &&  alloc_store) - st_done_now;
            if (ld_done_now) exp_ld <= step(exp_ld);
            if (st_done_now) exp_st <= step(exp_st);
            rd_pend <= (rd_pend || (mem_req_valid && !mem_req_write)) && !mem_rsp_valid;
        end
    end

    assert_ld_full_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !alloc_store && (int'(ld_cnt) - int'(ld_done_now) == DEPTH)) |-> !alloc_ready);

    assert_st_full_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_store && (int'(st_cnt) - int'(st_done_now) == DEPTH)) |-> !alloc_ready);

    assert_load_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done_now |-> (done_idx == exp_ld));

    assert_store_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_done_now |-> (done_idx == exp_st));

    assert_write_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> st_done_now);

    assert_single_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_write) |-> !rd_pend);
endmodule

bind mem_order_lsq lsq_checker #(.DEPTH(DEPTH)) u_lsq_chk (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_store(alloc_store), .alloc_ready(alloc_ready),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write), .mem_rsp_valid(mem_rsp_valid),
    .done_valid(done_valid), .done_store(done_store), .done_idx(done_idx)
);

// File: tb/tb_mem_order_lsq.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, a word memory model answering
// each read one cycle later, and logs of memory events and completions.
module tb_mem_order_lsq;
    localparam int DEPTH = 8;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int IW = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid = 1'b0, alloc_store = 1'b0;
    logic alloc_ready;
    logic [IW-1:0] alloc_idx;
    logic ld_wb_valid = 1'b0;
    logic [IW-1:0] ld_wb_idx = '0;
    logic [AW-1:0] ld_wb_addr = '0;
    logic st_wb_valid = 1'b0;
    logic [IW-1:0] st_wb_idx = '0;
    logic [AW-1:0] st_wb_addr = '0;
    logic [DW-1:0] st_wb_data = '0;
    logic mem_req_valid, mem_req_write;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;
    logic done_valid, done_store;
    logic [IW-1:0] done_idx;
    logic [DW-1:0] done_data;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] mem [64];
    logic          ev_wr   [256];
    logic [AW-1:0] ev_addr [256];
    logic [DW-1:0] ev_data [256];
    logic          dn_st   [256];
    logic [IW-1:0] dn_idx  [256];
    logic [DW-1:0] dn_data [256];
    int n_ev = 0;
    int n_dn = 0;

    always #2.5 clk = ~clk;

    mem_order_lsq #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_store(alloc_store),
        .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .ld_wb_valid(ld_wb_valid), .ld_wb_idx(ld_wb_idx), .ld_wb_addr(ld_wb_addr),
        .st_wb_valid(st_wb_valid), .st_wb_idx(st_wb_idx),
        .st_wb_addr(st_wb_addr), .st_wb_data(st_wb_data),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done_valid(done_valid), .done_store(done_store),
        .done_idx(done_idx), .done_data(done_data)
    );

    function automatic logic [DW-1:0] init_val(input int a);
        return 32'h1000 + DW'(a);
    endfunction

    // Memory model and event logging, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            mem_rsp_valid = 1'b0;
            if (mem_req_valid) begin
                ev_wr[n_ev] = mem_req_write;
                ev_addr[n_ev] = mem_req_addr;
                ev_data[n_ev] = mem_req_wdata;
                n_ev++;
                if (mem_req_write) begin
                    mem[mem_req_addr[5:0]] = mem_req_wdata;
                end else begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data = mem[mem_req_addr[5:0]];
                end
            end
            if (done_valid) begin
                dn_st[n_dn] = done_store;
                dn_idx[n_dn] = done_idx;
                dn_data[n_dn] = done_data;
                n_dn++;
            end
        end
    end

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_alloc(input logic st, output logic [IW-1:0] idx);
        @(negedge clk);
        alloc_valid = 1'b1;
        alloc_store = st;
        #0.5;
        idx = alloc_idx;
        chk("R1 alloc_ready with room", 32'(alloc_ready), 32'd1);
        @(posedge clk);
        #0.5;
        alloc_valid = 1'b0;
    endtask

    task automatic wb_ld(input logic [IW-1:0] idx, input int a);
        @(negedge clk);
        ld_wb_valid = 1'b1;
        ld_wb_idx = idx;
        ld_wb_addr = AW'(a);
        @(posedge clk);
        #0.5;
        ld_wb_valid = 1'b0;
    endtask

    task automatic wb_st(input logic [IW-1:0] idx, input int a, input logic [DW-1:0] d);
        @(negedge clk);
        st_wb_valid = 1'b1;
        st_wb_idx = idx;
        st_wb_addr = AW'(a);
        st_wb_data = d;
        @(posedge clk);
        #0.5;
        st_wb_valid = 1'b0;
    endtask

    task automatic chk_done(input string tag, input int k, input logic st,
                            input logic [IW-1:0] idx, input logic [DW-1:0] d);
        chk({tag, " kind"}, 32'(dn_st[k]), 32'(st));
        chk({tag, " index"}, 32'(dn_idx[k]), 32'(idx));
        chk({tag, " data"}, dn_data[k], d);
    endtask

    task automatic chk_ev(input string tag, input int k, input logic wr,
                          input int a, input logic [DW-1:0] d);
        chk({tag, " op"}, 32'(ev_wr[k]), 32'(wr));
        chk({tag, " addr"}, 32'(ev_addr[k]), 32'(a));
        if (wr) chk({tag, " wdata"}, ev_data[k], d);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R9 alloc_ready after reset", 32'(alloc_ready), 32'd1);
        chk("R9 alloc_idx after reset", 32'(alloc_idx), 32'd0);
        chk("R9 no request after reset", 32'(mem_req_valid), 32'd0);
        chk("R9 no completion after reset", 32'(done_valid), 32'd0);
    endtask

    task automatic t_read();
        logic [IW-1:0] a, b, c;
        int e0, d0;
        e0 = n_ev; d0 = n_dn;
        do_alloc(1'b0, a);
        chk("R1 first load index", 32'(a), 32'd0);
        wb_ld(a, 5);
        idle(5);
        chk("R8 one read", 32'(n_ev - e0), 32'd1);
        chk_ev("R8 read", e0, 1'b0, 5, '0);
        chk_done("R8 load result", d0, 1'b0, a, init_val(5));
        e0 = n_ev; d0 = n_dn;
        do_alloc(1'b0, b);
        do_alloc(1'b0, c);
        wb_ld(b, 6);
        wb_ld(c, 4);
        idle(8);
        chk("R8 two reads", 32'(n_ev - e0), 32'd2);
        chk_done("R8 second load", d0, 1'b0, b, init_val(6));
        chk_done("R8 third load", d0 + 1, 1'b0, c, init_val(4));
    endtask

    task automatic t_war_forward();
        logic [IW-1:0] l0, s1, l2;
        int e0, d0;
        e0 = n_ev; d0 = n_dn;
        do_alloc(1'b0, l0);
        do_alloc(1'b1, s1);
        do_alloc(1'b0, l2);
        wb_st(s1, 7, 32'hAAAA0007);
        idle(4);
        chk("R7 store held behind unknown older load", 32'(n_ev - e0), 32'd0);
        wb_ld(l2, 7);
        wb_ld(l0, 7);
        idle(8);
        chk("R4 single read only", 32'(n_ev - e0), 32'd2);
        chk_ev("R7 older load reads first", e0, 1'b0, 7, '0);
        chk_ev("R7 store writes after", e0 + 1, 1'b1, 7, 32'hAAAA0007);
        chk_done("R10 older load ignores younger store", d0, 1'b0, l0, init_val(7));
        chk_done("R4 forwarded load", d0 + 1, 1'b0, l2, 32'hAAAA0007);
        chk_done("R11 store completion", d0 + 2, 1'b1, s1, 32'hAAAA0007);
    endtask

    task automatic t_youngest();
        logic [IW-1:0] l0, s1, s2, l3;
        int e0, d0;
        e0 = n_ev; d0 = n_dn;
        do_alloc(1'b0, l0);
        do_alloc(1'b1, s1);
        do_alloc(1'b1, s2);
        do_alloc(1'b0, l3);
        wb_st(s1, 9, 32'hB1B1_0009);
        wb_st(s2, 9, 32'hB2B2_0009);
        wb_ld(l3, 9);
        wb_ld(l0, 9);
        idle(10);
        chk_done("R10 oldest load sees memory", d0, 1'b0, l0, init_val(9));
        chk_done("R5 youngest matching store forwarded", d0 + 1, 1'b0, l3, 32'hB2B2_0009);
        chk("R3 event count", 32'(n_ev - e0), 32'd3);
        chk_ev("R3 older store first", e0 + 1, 1'b1, 9, 32'hB1B1_0009);
        chk_ev("R3 younger store last", e0 + 2, 1'b1, 9, 32'hB2B2_0009);
        chk("R3 final memory value", mem[9], 32'hB2B2_0009);
        chk_done("R11 first store done", d0 + 2, 1'b1, s1, 32'hB1B1_0009);
    endtask

    task automatic t_unknown_store();
        logic [IW-1:0] s0, l1;
        int e0, d0;
        e0 = n_ev; d0 = n_dn;
        do_alloc(1'b1, s0);
        do_alloc(1'b0, l1);
        wb_ld(l1, 13);
        idle(6);
        chk("R6 no read while older store address unknown", 32'(n_ev - e0), 32'd0);
        chk("R6 no completion while waiting", 32'(n_dn - d0), 32'd0);
        wb_st(s0, 13, 32'hD00D_0013);
        idle(6);
        chk_done("R6 load released and forwarded", d0, 1'b0, l1, 32'hD00D_0013);
        chk("R4 only the store touches memory", 32'(n_ev - e0), 32'd1);
        chk_ev("R6 store write", e0, 1'b1, 13, 32'hD00D_0013);
    endtask

    task automatic t_store_passes();
        logic [IW-1:0] l0, s1;
        int e0, d0;
        e0 = n_ev; d0 = n_dn;
        do_alloc(1'b0, l0);
        do_alloc(1'b1, s1);
        wb_st(s1, 20, 32'hEEEE_0020);
        idle(5);
        chk("R7 store held on unknown load address", 32'(n_ev - e0), 32'd0);
        wb_ld(l0, 21);
        idle(6);
        chk_ev("R7 unrelated store writes first", e0, 1'b1, 20, 32'hEEEE_0020);
        chk_ev("R7 load reads after", e0 + 1, 1'b0, 21, '0);
        chk_done("R11 store done", d0, 1'b1, s1, 32'hEEEE_0020);
        chk_done("R8 load data", d0 + 1, 1'b0, l0, init_val(21));
    endtask

    task automatic t_full();
        logic [IW-1:0] li [DEPTH];
        logic [IW-1:0] si [DEPTH];
        int e0, d0;
        d0 = n_dn;
        for (int k = 0; k < DEPTH; k++) do_alloc(1'b0, li[k]);
        for (int k = 1; k < DEPTH; k++)
            chk("R1 load index wraps in order", 32'(li[k]), 32'((int'(li[0]) + k) % DEPTH));
        @(negedge clk);
        alloc_valid = 1'b1;
        alloc_store = 1'b0;
        #0.5;
        chk("R1 load allocation stalls when full", 32'(alloc_ready), 32'd0);
        alloc_store = 1'b1;
        #0.5;
        chk("R1 store allocation open while loads full", 32'(alloc_ready), 32'd1);
        alloc_valid = 1'b0;
        for (int k = DEPTH - 1; k >= 0; k--) wb_ld(li[k], 30 + k);
        idle(30);
        chk("R2 all loads done", 32'(n_dn - d0), 32'(DEPTH));
        for (int k = 0; k < DEPTH; k++)
            chk_done("R2 load order", d0 + k, 1'b0, li[k], init_val(30 + k));
        e0 = n_ev; d0 = n_dn;
        for (int k = 0; k < DEPTH; k++) do_alloc(1'b1, si[k]);
        @(negedge clk);
        alloc_valid = 1'b1;
        alloc_store = 1'b1;
        #0.5;
        chk("R1 store allocation stalls when full", 32'(alloc_ready), 32'd0);
        alloc_store = 1'b0;
        #0.5;
        chk("R1 load allocation open while stores full", 32'(alloc_ready), 32'd1);
        alloc_valid = 1'b0;
        for (int k = DEPTH - 1; k >= 0; k--) wb_st(si[k], 40 + k, 32'hC000_0000 + DW'(k));
        idle(20);
        chk("R3 all stores written", 32'(n_ev - e0), 32'(DEPTH));
        for (int k = 0; k < DEPTH; k++) begin
            chk_ev("R3 write order", e0 + k, 1'b1, 40 + k, 32'hC000_0000 + DW'(k));
            chk_done("R3 store completion order", d0 + k, 1'b1, si[k], 32'hC000_0000 + DW'(k));
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = init_val(i);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read();
        t_war_forward();
        t_youngest();
        t_unknown_store();
        t_store_passes();
        t_full();
        idle(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule